// File: doc/BRIEF.md
# Locality-aware multiple-bus allocator

This block decides which shared bus carries each transaction in a small multiple-bus interconnect. Every bus can link one processor to one memory module. Each request names a processor and a memory module. The block keeps three tables: one entry per bus (the pair it links), one per processor and one per memory module (the bus each sits on). A link stays in place after its transaction ends. A later request for the same pair therefore reuses the bus at once, with no switch reconfiguration.

When the pair is not linked, the block chooses a bus and emits a one-cycle reconfiguration command for the switch. One cycle later it emits the grant with the reconfigure flag set. The block prefers a bus that holds no link. If every bus is held, it evicts the least recently used bus that is not carrying a transaction. Any endpoint that moves to a new bus drops its old link, and the former partner on that old bus loses its link as well. So an endpoint is never linked on more than one bus.

Requests arrive over a valid/ready handshake. A request transfers on a clock edge where both are high. `req_ready` is worked out from the presented processor and memory fields and the block's own state, and it never depends on `req_valid`. Ready is low in the following cases:
- while either endpoint of the presented request sits on a bus that has an active transaction, meaning one that has been granted but has had no completion pulse yet;
- in the cycle after a request that needs reconfiguration has transferred;
- when no bus is free of an active transaction.

A sender that sees ready low holds the request steady until it transfers. Grants and reconfiguration commands are single-cycle pulses with no back-pressure.

Top module: `mbus_alloc`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every table entry to unlinked, marks every bus idle, sets the counters to zero and drives `grant_valid` and `cfg_valid` low. After reset, the first request for any pair is handled as a miss.
- R2: A transferred request whose processor and memory are linked on the same bus raises `grant_valid` in the next cycle. That grant carries `grant_reconf` = 0, `grant_bus` equal to the linking bus, and the request's processor and memory. No `cfg_valid` pulse is produced for it.
- R3: A transferred request whose pair is not linked raises `cfg_valid` for exactly one cycle in the next cycle, naming the chosen bus, the processor and the memory. `grant_valid` stays low in that cycle. In the cycle after that, `grant_valid` is high with `grant_reconf` = 1 and the same bus, processor and memory.
- R4: A link survives the completion pulse of its transaction. A later request for the same pair is a reuse grant on the same bus.
- R5: On a miss, if any bus holds no link, the chosen bus is the unlinked bus with the lowest index.
- R6: On a miss with every bus linked, the chosen bus is the least recently used bus among those without an active transaction. Recency is updated by every granted request on its bus. Reset orders recency by bus index, with bus 0 as the least recent. The evicted pair loses both of its endpoint links.
- R7: When a miss links processor p and memory m on bus b, any other bus that held p or m is cleared, together with the table entry of the partner endpoint on that bus. A later request by that partner for its old pair is therefore a miss.
- R8: A bus is active from the transfer of a request granted on it until a `done_valid` pulse with `done_bus` naming it. `req_ready` is low while an endpoint of the presented request is linked on an active bus, and it is low in the cycle right after a miss transfers. A bus that is active is never chosen for reconfiguration.
- R9: `cnt_grants` increases by one in the same cycle as each grant pulse. `cnt_reconf` increases by one with each grant pulse that has `grant_reconf` = 1. Both counters wrap at their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can transfer this edge |
| req_proc | input | PW | Requesting processor index |
| req_mem | input | MW | Target memory module index |
| done_valid | input | 1 | Completion pulse for an active transaction |
| done_bus | input | BW | Bus whose transaction has completed |
| cfg_valid | output | 1 | Switch reconfiguration command |
| cfg_bus | output | BW | Bus to reconfigure |
| cfg_proc | output | PW | Processor to attach to that bus |
| cfg_mem | output | MW | Memory to attach to that bus |
| grant_valid | output | 1 | Grant pulse |
| grant_reconf | output | 1 | Grant follows a reconfiguration |
| grant_bus | output | BW | Bus carrying the transaction |
| grant_proc | output | PW | Processor of the granted transaction |
| grant_mem | output | MW | Memory of the granted transaction |
| cnt_grants | output | CNT_W | Total grants |
| cnt_reconf | output | CNT_W | Grants that needed reconfiguration |

## Verification
The assertions assume three things about the inputs. First, `req_proc` and `req_mem` are in range. Second, `done_valid` only names a bus whose transaction has been granted and not yet completed. Third, a waiting request is held steady. The stimulus keeps to all three. Each request it issues uses indices drawn below the configured counts. It sends a completion pulse only for the bus just granted, and only after the grant has been seen. It keeps `req_valid` and the payload fixed from the cycle it raises them until the handshake. Random pairs produce a mix of reuse, free-bus and eviction cases. A directed stall case leaves one transaction open while a request that shares an endpoint waits.

// File: rtl/mba_pkg.sv
package mba_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CFG  = 1'b1
  } mba_state_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mba_table.sv
module mba_table #(
  parameter int NPROC = 2,
  parameter int NMEM  = 2,
  parameter int NBUS  = 2,
  localparam int PW = mba_pkg::idx_w(NPROC),
  localparam int MW = mba_pkg::idx_w(NMEM),
  localparam int BW = mba_pkg::idx_w(NBUS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic                     upd_miss,
  input  logic [PW-1:0]            req_proc,
  input  logic [MW-1:0]            req_mem,
  input  logic [BW-1:0]            use_bus,
  input  logic                     done_valid,
  input  logic [BW-1:0]            done_bus,
  output logic [NBUS-1:0]          bus_link,
  output logic [NBUS-1:0][PW-1:0]  bus_proc,
  output logic [NBUS-1:0][MW-1:0]  bus_mem,
  output logic [NBUS-1:0]          bus_busy,
  output logic [NPROC-1:0]         proc_link,
  output logic [NPROC-1:0][BW-1:0] proc_bus,
  output logic [NMEM-1:0]          mem_link,
  output logic [NMEM-1:0][BW-1:0]  mem_bus
);
  logic [NBUS-1:0]          nb_link;
  logic [NBUS-1:0][PW-1:0]  nb_proc;
  logic [NBUS-1:0][MW-1:0]  nb_mem;
  logic [NBUS-1:0]          nb_busy;
  logic [NPROC-1:0]         np_link;
  logic [NPROC-1:0][BW-1:0] np_bus;
  logic [NMEM-1:0]          nm_link;
  logic [NMEM-1:0][BW-1:0]  nm_bus;

  always_comb begin
    nb_link = bus_link;
    nb_proc = bus_proc;
    nb_mem  = bus_mem;
    nb_busy = bus_busy;
    np_link = proc_link;
    np_bus  = proc_bus;
    nm_link = mem_link;
    nm_bus  = mem_bus;
    if (upd && upd_miss) begin
      // drop the pair that currently owns the chosen bus
      if (bus_link[use_bus]) begin
        np_link[bus_proc[use_bus]] = 1'b0;
        nm_link[bus_mem[use_bus]]  = 1'b0;
      end
      // the processor leaves its old bus; that bus and its partner go idle
      if (proc_link[req_proc] && proc_bus[req_proc] != use_bus) begin
        nb_link[proc_bus[req_proc]]          = 1'b0;
        nm_link[bus_mem[proc_bus[req_proc]]] = 1'b0;
      end
      // the memory leaves its old bus likewise
      if (mem_link[req_mem] && mem_bus[req_mem] != use_bus) begin
        nb_link[mem_bus[req_mem]]           = 1'b0;
        np_link[bus_proc[mem_bus[req_mem]]] = 1'b0;
      end
      nb_link[use_bus]  = 1'b1;
      nb_proc[use_bus]  = req_proc;
      nb_mem[use_bus]   = req_mem;
      np_link[req_proc] = 1'b1;
      np_bus[req_proc]  = use_bus;
      nm_link[req_mem]  = 1'b1;
      nm_bus[req_mem]   = use_bus;
    end
    if (done_valid) nb_busy[done_bus] = 1'b0;
    if (upd)        nb_busy[use_bus]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_link  <= '0;
      bus_proc  <= '0;
      bus_mem   <= '0;
      bus_busy  <= '0;
      proc_link <= '0;
      proc_bus  <= '0;
      mem_link  <= '0;
      mem_bus   <= '0;
    end else begin
      bus_link  <= nb_link;
      bus_proc  <= nb_proc;
      bus_mem   <= nb_mem;
      bus_busy  <= nb_busy;
      proc_link <= np_link;
      proc_bus  <= np_bus;
      mem_link  <= nm_link;
      mem_bus   <= nm_bus;
    end
  end

  // R1: after a reset edge every table is empty
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (bus_link == '0 && proc_link == '0 && mem_link == '0 && bus_busy == '0));

  for (genvar p = 0; p < NPROC; p++) begin : g_pchk
    logic [NBUS-1:0] hold_vec;
    always_comb begin
      for (int b = 0; b < NBUS; b++)
        hold_vec[b] = bus_link[b] && (bus_proc[b] == PW'(p));
    end
    // R7: a processor is linked on at most one bus, and the tables agree
    assert_proc_single_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(hold_vec) <= 1);
    assert_proc_agree_R7: assert property (@(posedge clk) disable iff (rst)
      proc_link[p] |-> (bus_link[proc_bus[p]] && bus_proc[proc_bus[p]] == PW'(p)));
  end

  for (genvar m = 0; m < NMEM; m++) begin : g_mchk
    logic [NBUS-1:0] hold_vec;
    always_comb begin
      for (int b = 0; b < NBUS; b++)
        hold_vec[b] = bus_link[b] && (bus_mem[b] == MW'(m));
    end
    assert_mem_single_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(hold_vec) <= 1);
    assert_mem_agree_R7: assert property (@(posedge clk) disable iff (rst)
      mem_link[m] |-> (bus_link[mem_bus[m]] && bus_mem[mem_bus[m]] == MW'(m)));
  end
endmodule

// File: rtl/mba_lru.sv
module mba_lru #(
  parameter int NBUS = 2,
  localparam int BW = mba_pkg::idx_w(NBUS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    touch,
  input  logic [BW-1:0]           touch_bus,
  output logic [NBUS-1:0][BW-1:0] rank
);
  // rank 0 is least recent, NBUS-1 most recent
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUS; i++) rank[i] <= BW'(i);
    end else if (touch) begin
      for (int i = 0; i < NBUS; i++) begin
        if (BW'(i) == touch_bus)             rank[i] <= BW'(NBUS - 1);
        else if (rank[i] > rank[touch_bus])  rank[i] <= rank[i] - BW'(1);
      end
    end
  end

  // R6: the ranks always form a permutation
  for (genvar r = 0; r < NBUS; r++) begin : g_perm
    logic [NBUS-1:0] hit_vec;
    always_comb begin
      for (int i = 0; i < NBUS; i++) hit_vec[i] = (rank[i] == BW'(r));
    end
    assert_rank_unique_R6: assert property (@(posedge clk) disable iff (rst)
      $countones(hit_vec) == 1);
  end
endmodule

// File: rtl/mba_pick.sv
module mba_pick #(
  parameter int NPROC = 2,
  parameter int NMEM  = 2,
  parameter int NBUS  = 2,
  localparam int PW = mba_pkg::idx_w(NPROC),
  localparam int MW = mba_pkg::idx_w(NMEM),
  localparam int BW = mba_pkg::idx_w(NBUS)
) (
  input  logic [PW-1:0]            req_proc,
  input  logic [MW-1:0]            req_mem,
  input  logic [NBUS-1:0]          bus_link,
  input  logic [NBUS-1:0]          bus_busy,
  input  logic [NPROC-1:0]         proc_link,
  input  logic [NPROC-1:0][BW-1:0] proc_bus,
  input  logic [NMEM-1:0]          mem_link,
  input  logic [NMEM-1:0][BW-1:0]  mem_bus,
  input  logic [NBUS-1:0][BW-1:0]  rank,
  output logic                     hit,
  output logic [BW-1:0]            hit_bus,
  output logic                     ep_busy,
  output logic                     have_bus,
  output logic [BW-1:0]            sel_bus
);
  logic          free_found;
  logic [BW-1:0] free_sel;
  logic          lru_found;
  logic [BW-1:0] lru_sel;
  logic [BW-1:0] lru_rank;

  always_comb begin
    hit     = proc_link[req_proc] && mem_link[req_mem] &&
              (proc_bus[req_proc] == mem_bus[req_mem]);
    hit_bus = proc_bus[req_proc];
    ep_busy = (proc_link[req_proc] && bus_busy[proc_bus[req_proc]]) ||
              (mem_link[req_mem]   && bus_busy[mem_bus[req_mem]]);
  end

  always_comb begin
    free_found = 1'b0;
    free_sel   = '0;
    for (int i = NBUS - 1; i >= 0; i--) begin
      if (!bus_link[i]) begin
        free_found = 1'b1;
        free_sel   = BW'(i);
      end
    end
  end

  always_comb begin
    lru_found = 1'b0;
    lru_sel   = '0;
    lru_rank  = '0;
    for (int i = 0; i < NBUS; i++) begin
      if (!bus_busy[i] && (!lru_found || rank[i] < lru_rank)) begin
        lru_found = 1'b1;
        lru_sel   = BW'(i);
        lru_rank  = rank[i];
      end
    end
  end

  assign have_bus = free_found || lru_found;
  assign sel_bus  = free_found ? free_sel : lru_sel;
endmodule

// File: rtl/mba_ctrl.sv
module mba_ctrl #(
  parameter int NPROC = 2,
  parameter int NMEM  = 2,
  parameter int NBUS  = 2,
  parameter int CNT_W = 16,
  localparam int PW = mba_pkg::idx_w(NPROC),
  localparam int MW = mba_pkg::idx_w(NMEM),
  localparam int BW = mba_pkg::idx_w(NBUS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [PW-1:0]    req_proc,
  input  logic [MW-1:0]    req_mem,
  input  logic             hit,
  input  logic [BW-1:0]    hit_bus,
  input  logic             ep_busy,
  input  logic             have_bus,
  input  logic [BW-1:0]    sel_bus,
  output logic             req_ready,
  output logic             accept,
  output logic             cfg_valid,
  output logic [BW-1:0]    cfg_bus,
  output logic [PW-1:0]    cfg_proc,
  output logic [MW-1:0]    cfg_mem,
  output logic             grant_valid,
  output logic             grant_reconf,
  output logic [BW-1:0]    grant_bus,
  output logic [PW-1:0]    grant_proc,
  output logic [MW-1:0]    grant_mem,
  output logic [CNT_W-1:0] cnt_grants,
  output logic [CNT_W-1:0] cnt_reconf
);
  import mba_pkg::*;

  mba_state_t state;

  assign req_ready = (state == ST_IDLE) && !ep_busy && (hit || have_bus);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cfg_valid    <= 1'b0;
      cfg_bus      <= '0;
      cfg_proc     <= '0;
      cfg_mem      <= '0;
      grant_valid  <= 1'b0;
      grant_reconf <= 1'b0;
      grant_bus    <= '0;
      grant_proc   <= '0;
      grant_mem    <= '0;
      cnt_grants   <= '0;
      cnt_reconf   <= '0;
    end else begin
      grant_valid <= 1'b0;
      cfg_valid   <= 1'b0;
      if (state == ST_CFG) begin
        state        <= ST_IDLE;
        grant_valid  <= 1'b1;
        grant_reconf <= 1'b1;
        grant_bus    <= cfg_bus;
        grant_proc   <= cfg_proc;
        grant_mem    <= cfg_mem;
        cnt_grants   <= cnt_grants + CNT_W'(1);
        cnt_reconf   <= cnt_reconf + CNT_W'(1);
      end else if (accept) begin
        if (hit) begin
          grant_valid  <= 1'b1;
          grant_reconf <= 1'b0;
          grant_bus    <= hit_bus;
          grant_proc   <= req_proc;
          grant_mem    <= req_mem;
          cnt_grants   <= cnt_grants + CNT_W'(1);
        end else begin
          state     <= ST_CFG;
          cfg_valid <= 1'b1;
          cfg_bus   <= sel_bus;
          cfg_proc  <= req_proc;
          cfg_mem   <= req_mem;
        end
      end
    end
  end

  // R3: a reconfiguration command is followed by its grant on the same bus
  assert_cfg_then_grant_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> (grant_valid && grant_reconf && grant_bus == $past(cfg_bus)
                   && !cfg_valid));
  // R2: a reuse grant comes one cycle after a transfer
  assert_reuse_timing_R2: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !grant_reconf) |-> $past(accept));
  // R8: no transfer in the cycle right after a miss transfers
  assert_miss_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> !req_ready);
  // R9: the reconfiguration counter steps with each reconfigured grant
  assert_reconf_count_R9: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && grant_reconf) |-> cnt_reconf == $past(cnt_reconf) + CNT_W'(1));
endmodule

// File: rtl/mbus_alloc.sv
module mbus_alloc #(
  parameter int NPROC = 2,
  parameter int NMEM  = 2,
  parameter int NBUS  = 2,
  parameter int CNT_W = 16,
  localparam int PW = mba_pkg::idx_w(NPROC),
  localparam int MW = mba_pkg::idx_w(NMEM),
  localparam int BW = mba_pkg::idx_w(NBUS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PW-1:0]    req_proc,
  input  logic [MW-1:0]    req_mem,
  input  logic             done_valid,
  input  logic [BW-1:0]    done_bus,
  output logic             cfg_valid,
  output logic [BW-1:0]    cfg_bus,
  output logic [PW-1:0]    cfg_proc,
  output logic [MW-1:0]    cfg_mem,
  output logic             grant_valid,
  output logic             grant_reconf,
  output logic [BW-1:0]    grant_bus,
  output logic [PW-1:0]    grant_proc,
  output logic [MW-1:0]    grant_mem,
  output logic [CNT_W-1:0] cnt_grants,
  output logic [CNT_W-1:0] cnt_reconf
);
  logic [NBUS-1:0]          bus_link;
  logic [NBUS-1:0][PW-1:0]  bus_proc;
  logic [NBUS-1:0][MW-1:0]  bus_mem;
  logic [NBUS-1:0]          bus_busy;
  logic [NPROC-1:0]         proc_link;
  logic [NPROC-1:0][BW-1:0] proc_bus;
  logic [NMEM-1:0]          mem_link;
  logic [NMEM-1:0][BW-1:0]  mem_bus;
  logic [NBUS-1:0][BW-1:0]  rank;
  logic                     hit, ep_busy, have_bus, accept;
  logic [BW-1:0]            hit_bus, sel_bus, use_bus;

  assign use_bus = hit ? hit_bus : sel_bus;

  mba_table #(.NPROC(NPROC), .NMEM(NMEM), .NBUS(NBUS)) u_table (
    .clk(clk), .rst(rst), .upd(accept), .upd_miss(!hit),
    .req_proc(req_proc), .req_mem(req_mem), .use_bus(use_bus),
    .done_valid(done_valid), .done_bus(done_bus),
    .bus_link(bus_link), .bus_proc(bus_proc), .bus_mem(bus_mem), .bus_busy(bus_busy),
    .proc_link(proc_link), .proc_bus(proc_bus), .mem_link(mem_link), .mem_bus(mem_bus)
  );

  mba_lru #(.NBUS(NBUS)) u_lru (
    .clk(clk), .rst(rst), .touch(accept), .touch_bus(use_bus), .rank(rank)
  );

  mba_pick #(.NPROC(NPROC), .NMEM(NMEM), .NBUS(NBUS)) u_pick (
    .req_proc(req_proc), .req_mem(req_mem), .bus_link(bus_link), .bus_busy(bus_busy),
    .proc_link(proc_link), .proc_bus(proc_bus), .mem_link(mem_link), .mem_bus(mem_bus),
    .rank(rank), .hit(hit), .hit_bus(hit_bus), .ep_busy(ep_busy),
    .have_bus(have_bus), .sel_bus(sel_bus)
  );

  mba_ctrl #(.NPROC(NPROC), .NMEM(NMEM), .NBUS(NBUS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_proc(req_proc), .req_mem(req_mem),
    .hit(hit), .hit_bus(hit_bus), .ep_busy(ep_busy), .have_bus(have_bus), .sel_bus(sel_bus),
    .req_ready(req_ready), .accept(accept),
    .cfg_valid(cfg_valid), .cfg_bus(cfg_bus), .cfg_proc(cfg_proc), .cfg_mem(cfg_mem),
    .grant_valid(grant_valid), .grant_reconf(grant_reconf), .grant_bus(grant_bus),
    .grant_proc(grant_proc), .grant_mem(grant_mem),
    .cnt_grants(cnt_grants), .cnt_reconf(cnt_reconf)
  );

  // R8: an active bus is never handed to a reconfiguration
  assert_no_busy_reconf_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |-> !bus_busy[sel_bus]);
  // R2: a reuse transfer never reaches a bus that is active
  assert_hit_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (accept && hit) |-> !bus_busy[hit_bus]);
endmodule

// File: tb/tb_mbus_alloc.sv
module tb_mbus_alloc;
  localparam int NP = 2, NM = 2, NB = 2, CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [0:0] req_proc = '0;
  logic [0:0] req_mem = '0;
  logic done_valid = 1'b0;
  logic [0:0] done_bus = '0;
  logic cfg_valid, grant_valid, grant_reconf;
  logic [0:0] cfg_bus, cfg_proc, cfg_mem, grant_bus, grant_proc, grant_mem;
  logic [CW-1:0] cnt_grants, cnt_reconf;

  always #10 clk = ~clk;

  mbus_alloc #(.NPROC(NP), .NMEM(NM), .NBUS(NB), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_proc(req_proc), .req_mem(req_mem), .done_valid(done_valid), .done_bus(done_bus),
    .cfg_valid(cfg_valid), .cfg_bus(cfg_bus), .cfg_proc(cfg_proc), .cfg_mem(cfg_mem),
    .grant_valid(grant_valid), .grant_reconf(grant_reconf), .grant_bus(grant_bus),
    .grant_proc(grant_proc), .grant_mem(grant_mem),
    .cnt_grants(cnt_grants), .cnt_reconf(cnt_reconf)
  );

  int errors = 0, checks = 0;
  int exp_grants = 0, exp_reconf = 0;
  bit finished = 0;

  // reference tables built from the requirements
  bit mb_link[NB]; int mb_proc[NB]; int mb_mem[NB]; bit mb_busy[NB]; int mrank[NB];
  bit mp_link[NP]; int mp_bus[NP];
  bit mm_link[NM]; int mm_bus[NM];

  task automatic chk(input string req, input bit ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      mb_link[b] = 0; mb_busy[b] = 0; mrank[b] = b; mb_proc[b] = 0; mb_mem[b] = 0;
    end
    for (int p = 0; p < NP; p++) mp_link[p] = 0;
    for (int m = 0; m < NM; m++) mm_link[m] = 0;
  endtask

  function automatic bit model_hit(input int p, input int m);
    return mp_link[p] && mm_link[m] && mp_bus[p] == mm_bus[m];
  endfunction

  function automatic int model_pick();
    int best; best = -1;
    for (int b = 0; b < NB; b++) if (!mb_link[b]) return b;           // R5
    for (int b = 0; b < NB; b++)                                       // R6
      if (!mb_busy[b] && (best < 0 || mrank[b] < mrank[best])) best = b;
    return best;
  endfunction

  task automatic model_commit(input int p, input int m, input bit h, input int bsel);
    int old;
    if (!h) begin
      if (mb_link[bsel]) begin mp_link[mb_proc[bsel]] = 0; mm_link[mb_mem[bsel]] = 0; end
      if (mp_link[p] && mp_bus[p] != bsel) begin
        mb_link[mp_bus[p]] = 0; mm_link[mb_mem[mp_bus[p]]] = 0;
      end
      if (mm_link[m] && mm_bus[m] != bsel) begin
        mb_link[mm_bus[m]] = 0; mp_link[mb_proc[mm_bus[m]]] = 0;
      end
      mb_link[bsel] = 1; mb_proc[bsel] = p; mb_mem[bsel] = m;
      mp_link[p] = 1; mp_bus[p] = bsel; mm_link[m] = 1; mm_bus[m] = bsel;
    end
    mb_busy[bsel] = 1;
    old = mrank[bsel];
    for (int b = 0; b < NB; b++) begin
      if (b == bsel) mrank[b] = NB - 1;
      else if (mrank[b] > old) mrank[b]--;
    end
  endtask

  // one request; stall_bus >= 0 means the request must wait for that bus first
  task automatic transact(input int p, input int m, input bit do_done, input int stall_bus,
                          output bit was_hit, output int used_bus);
    bit h; int b;
    @(negedge clk);
    req_valid = 1'b1; req_proc = 1'(p); req_mem = 1'(m);
    #1;
    if (stall_bus >= 0) begin
      for (int k = 0; k < 3; k++) begin
        chk("R8 stall ready", req_ready == 1'b0, req_ready, 0);
        @(negedge clk); #1;
      end
      done_valid = 1'b1; done_bus = 1'(stall_bus);
      chk("R8 stall ready at done", req_ready == 1'b0, req_ready, 0);
      @(negedge clk);
      done_valid = 1'b0;
      mb_busy[stall_bus] = 0;
      #1;
    end
    h = model_hit(p, m);
    b = h ? mp_bus[p] : model_pick();
    chk("R8 ready", req_ready == 1'b1, req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (h) begin
      exp_grants++;
      chk("R2 grant_valid", grant_valid == 1'b1, grant_valid, 1);
      chk("R2 reconf low", grant_reconf == 1'b0, grant_reconf, 0);
      chk("R2 reuse bus", int'(grant_bus) == b, grant_bus, b);
      chk("R2 no cfg", cfg_valid == 1'b0, cfg_valid, 0);
      chk("R2 grant pair", int'(grant_proc) == p && int'(grant_mem) == m, grant_proc, p);
    end else begin
      chk("R3 cfg_valid", cfg_valid == 1'b1, cfg_valid, 1);
      chk("R3 no early grant", grant_valid == 1'b0, grant_valid, 0);
      chk("R5 R6 chosen bus", int'(cfg_bus) == b, cfg_bus, b);
      chk("R3 cfg pair", int'(cfg_proc) == p && int'(cfg_mem) == m, cfg_proc, p);
      @(negedge clk); #1;
      exp_grants++; exp_reconf++;
      chk("R3 grant_valid", grant_valid == 1'b1, grant_valid, 1);
      chk("R3 reconf high", grant_reconf == 1'b1, grant_reconf, 1);
      chk("R3 grant bus", int'(grant_bus) == b, grant_bus, b);
      chk("R3 cfg one cycle", cfg_valid == 1'b0, cfg_valid, 0);
    end
    chk("R9 grant count", int'(cnt_grants) == exp_grants, cnt_grants, exp_grants);
    chk("R9 reconf count", int'(cnt_reconf) == exp_reconf, cnt_reconf, exp_reconf);
    model_commit(p, m, h, b);
    if (do_done) begin
      @(negedge clk);
      done_valid = 1'b1; done_bus = 1'(b);
      @(negedge clk);
      done_valid = 1'b0;
      mb_busy[b] = 0;
    end
    was_hit = h; used_bus = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit h; int b, hold_b;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 grant low", grant_valid == 1'b0, grant_valid, 0);
    chk("R1 cfg low", cfg_valid == 1'b0, cfg_valid, 0);
    chk("R1 counters", cnt_grants == '0 && cnt_reconf == '0, cnt_grants, 0);

    transact(0, 0, 1, -1, h, b);
    chk("R1 first is miss", h == 0 && b == 0, b, 0);            // R5 lowest free
    transact(0, 0, 1, -1, h, b);
    chk("R4 link kept after done", h == 1 && b == 0, b, 0);
    transact(1, 1, 1, -1, h, b);
    chk("R5 free bus one", h == 0 && b == 1, b, 1);
    transact(1, 1, 1, -1, h, b);
    transact(0, 1, 1, -1, h, b);
    chk("R6 LRU eviction bus0", h == 0 && b == 0, b, 0);
    transact(1, 1, 1, -1, h, b);
    chk("R7 partner dropped, free bus1", h == 0 && b == 1, b, 1);
    transact(0, 1, 1, -1, h, b);
    chk("R7 old pair is miss", h == 0, h, 0);
    // R8 stall: leave a transaction open, then ask with a shared endpoint
    transact(1, 0, 0, -1, h, hold_b);
    transact(1, 1, 1, hold_b, h, b);

    for (int n = 0; n < 400; n++) begin
      int p, m;
      p = int'($urandom_range(NP - 1));
      m = int'($urandom_range(NM - 1));
      transact(p, m, 1, -1, h, b);
    end
    @(negedge clk); #1;
    chk("R9 final grants", int'(cnt_grants) == exp_grants, cnt_grants, exp_grants);
    chk("R9 final reconf", int'(cnt_reconf) == exp_reconf, cnt_reconf, exp_reconf);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule